// File: doc/BRIEF.md
# Connection-Memory Bulk Fill Controller

This controller sits inside a time-slot-interchange switch. On a host command it writes one common word into every location of the connection memory. The host sets it up through a 16-bit mode register. That register holds:

- a 5-bit fill pattern;
- a fill-start bit;
- an output-standby bit;
- a stored evaluation-start bit;
- a 2-bit line-rate code.

A separate permission input, taken from the control register, must be high before a fill can begin. Frame pulses from the timing generator pace the work.

A fill begins with a host write that raises the start bit while permission is granted. The state machine moves from IDLE to ARMED on that write (transition "arm"). From ARMED it moves to SWEEP_A at the next frame pulse ("launch"). From SWEEP_A it moves to SWEEP_B at the following frame pulse ("half"). From SWEEP_B it returns to IDLE at the frame pulse after that ("finish"), and the start bit clears itself at that point.

During SWEEP_A and SWEEP_B the controller writes one word per clock, at addresses 0 upward to the memory depth minus one. Each word carries the pattern in its top five bits and zeros below. The host can abort a fill at any point. Clearing the start bit, or dropping permission, returns ARMED, SWEEP_A or SWEEP_B to IDLE ("abort"). The same register also decides whether the serial outputs float, and it supplies the effective line rate.

Top module: `cmf_bulk_init`

## Requirements
- R1: After reset the mode register reads 0000h. A write to address 1 stores bits 9..0, and bits 15..10 always read 0. The read port returns the register contents at all times.
- R2: A fill starts only from a write that takes the start bit (bit 4) from 0 to 1 while `blk_prog_permit` is 1. A start write made without permission stores the bit but produces no memory writes. Rewriting a start bit that is already 1 produces no memory writes.
- R3: Memory writes begin in the cycle after the first frame pulse that follows the start write. There is one write per clock, at addresses 0, 1, 2 … up to depth−1, and each address is written exactly once. No write occurs while the controller waits for that frame pulse.
- R4: Every fill write carries the pattern field (register bits 9..5) in data bits 15..11, with data bits 10..0 equal to 0.
- R5: The start bit reads 1 until the second frame pulse after the sweep has begun. At that pulse it clears to 0.
- R6: A write that clears the start bit during a fill stops memory writes from the next cycle on. Words that have already been written keep their values, and words that have not been written keep their old contents.
- R7: Dropping `blk_prog_permit` during a fill blocks memory writes in that same cycle. The start bit reads 0 from the next clock edge, and no further writes follow.
- R8: `out_hiz` is 1 exactly when `drive_en_in` is 0 and the standby bit (bit 3) is 0.
- R9: `rate_sel` follows rate code bits 1..0: 00 gives 2.048 Mb/s, 01 gives 4.096 Mb/s and 10 gives 8.192 Mb/s. Code 11 is stored and read back as 11, but `rate_sel` gives 00.
- R10: A write to any address other than 1 leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Host register write strobe |
| reg_wr_addr | input | 4 | Host register address |
| reg_wr_data | input | 16 | Host write data |
| reg_rd_data | output | 16 | Mode register contents |
| blk_prog_permit | input | 1 | Fill permission from the control register |
| frame_pulse | input | 1 | One-cycle frame boundary pulse |
| drive_en_in | input | 1 | External output-drive enable |
| out_hiz | output | 1 | 1 = serial outputs in high impedance |
| rate_sel | output | 2 | Effective line-rate code |
| cm_wr_en | output | 1 | Connection-memory write enable |
| cm_wr_addr | output | CM_AW | Connection-memory write address |
| cm_wr_data | output | 16 | Connection-memory write data |

## Verification
If the state register goes wrong, the effect shows in one of three ways:

- `cm_wr_en` rises while the controller should still be waiting;
- `cm_wr_en` never rises;
- the start bit fails to drop on `reg_rd_data` at the finishing frame pulse.

Each of these is visible within one frame of the bad state. If the address counter goes wrong, the written addresses skip or repeat. The bench catches that on the first bad write by comparing every address with the previous one plus one. An abort that fails to take effect leaves writes running after the cancelling write or the permission drop. Words past the cut point are then overwritten, and the bench finds this when it reads back its memory model.

// File: rtl/cmf_pkg.sv
package cmf_pkg;
    localparam int WORD_W    = 16;
    localparam int PAT_W     = 5;
    localparam int PAT_LSB   = 5;
    localparam int START_BIT = 4;
    localparam int STBY_BIT  = 3;
    localparam int RATE_LSB  = 0;
    localparam int LOW_W     = WORD_W - PAT_W;
    localparam logic [WORD_W-1:0] USED_MASK = 16'h03FF;

    typedef enum logic [1:0] {
        FS_IDLE    = 2'd0,
        FS_ARMED   = 2'd1,
        FS_SWEEP_A = 2'd2,
        FS_SWEEP_B = 2'd3
    } fill_state_e;

    typedef enum logic [1:0] {
        RATE_2M  = 2'b00,
        RATE_4M  = 2'b01,
        RATE_8M  = 2'b10,
        RATE_RSV = 2'b11
    } rate_e;
endpackage

// File: rtl/cmf_mode_reg.sv
module cmf_mode_reg
    import cmf_pkg::*;
#(
    parameter int RA_W      = 4,
    parameter int MODE_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RA_W-1:0]   wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              clr_start,
    output logic [WORD_W-1:0] mode_q,
    output logic              start_rise
);
    logic hit;

    assign hit        = wr_en && (wr_addr == RA_W'(MODE_ADDR));
    assign start_rise = hit && wr_data[START_BIT] && !mode_q[START_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else begin
            if (hit)       mode_q <= wr_data & USED_MASK;
            if (clr_start) mode_q[START_BIT] <= 1'b0;
        end
    end

    AST_MISS_KEEPS_REG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != RA_W'(MODE_ADDR) && !clr_start) |=> $stable(mode_q)); // R10
endmodule

// File: rtl/cmf_fill_fsm.sv
module cmf_fill_fsm
    import cmf_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_rise,
    input  logic          start_q,
    input  logic          permit,
    input  logic          frame_pulse,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic          clr_start,
    output fill_state_e   state_o
);
    localparam int CW = AW + 1;

    fill_state_e state, state_n;
    logic [CW-1:0] cnt;
    logic abort, sweeping;

    assign abort    = !start_q || !permit;
    assign sweeping = (state == FS_SWEEP_A) || (state == FS_SWEEP_B);

    always_comb begin
        state_n = state;
        unique case (state)
            FS_IDLE:    if (start_rise && permit) state_n = FS_ARMED;
            FS_ARMED:   if (abort) state_n = FS_IDLE;
                        else if (frame_pulse) state_n = FS_SWEEP_A;
            FS_SWEEP_A: if (abort) state_n = FS_IDLE;
                        else if (frame_pulse) state_n = FS_SWEEP_B;
            FS_SWEEP_B: if (abort || frame_pulse) state_n = FS_IDLE;
            default:    state_n = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FS_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            if (!sweeping)  cnt <= '0;
            else if (wr_en) cnt <= cnt + CW'(1);
        end
    end

    always_comb begin
        wr_en     = sweeping && (cnt < CW'(DEPTH)) && !abort;
        wr_addr   = cnt[AW-1:0];
        clr_start = ((state != FS_IDLE) && abort) ||
                    ((state == FS_SWEEP_B) && frame_pulse);
        state_o   = state;
    end

    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ({1'b0, wr_addr} < CW'(DEPTH))); // R3
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + AW'(1))); // R3
    AST_ARM_NEEDS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == FS_IDLE && state == FS_ARMED) |-> $past(permit)); // R2
endmodule

// File: rtl/cmf_out_ctrl.sv
module cmf_out_ctrl
    import cmf_pkg::*;
(
    input  logic       drive_en,
    input  logic       standby,
    input  logic [1:0] rate_code,
    output logic       out_hiz,
    output logic [1:0] rate_sel
);
    always_comb begin
        out_hiz = !drive_en && !standby;
        unique case (rate_e'(rate_code))
            RATE_4M: rate_sel = RATE_4M;
            RATE_8M: rate_sel = RATE_8M;
            default: rate_sel = RATE_2M;
        endcase
    end

    always_comb begin
        if (!$isunknown(rate_code))
            AST_RATE_LEGAL: assert (rate_sel != RATE_RSV); // R9
    end
endmodule

// File: rtl/cmf_bulk_init.sv
module cmf_bulk_init
    import cmf_pkg::*;
#(
    parameter  int CM_DEPTH  = 2048,
    parameter  int RA_W      = 4,
    parameter  int MODE_ADDR = 1,
    localparam int CM_AW     = (CM_DEPTH > 1) ? $clog2(CM_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [RA_W-1:0]   reg_wr_addr,
    input  logic [WORD_W-1:0] reg_wr_data,
    output logic [WORD_W-1:0] reg_rd_data,
    input  logic              blk_prog_permit,
    input  logic              frame_pulse,
    input  logic              drive_en_in,
    output logic              out_hiz,
    output logic [1:0]        rate_sel,
    output logic              cm_wr_en,
    output logic [CM_AW-1:0]  cm_wr_addr,
    output logic [WORD_W-1:0] cm_wr_data
);
    logic [WORD_W-1:0] mode_q;
    logic start_rise, clr_start;
    fill_state_e fsm_state;

    cmf_mode_reg #(.RA_W(RA_W), .MODE_ADDR(MODE_ADDR)) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_addr(reg_wr_addr),
        .wr_data(reg_wr_data), .clr_start(clr_start),
        .mode_q(mode_q), .start_rise(start_rise)
    );

    cmf_fill_fsm #(.DEPTH(CM_DEPTH), .AW(CM_AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_rise(start_rise),
        .start_q(mode_q[START_BIT]), .permit(blk_prog_permit),
        .frame_pulse(frame_pulse), .wr_en(cm_wr_en), .wr_addr(cm_wr_addr),
        .clr_start(clr_start), .state_o(fsm_state)
    );

    cmf_out_ctrl u_out (
        .drive_en(drive_en_in), .standby(mode_q[STBY_BIT]),
        .rate_code(mode_q[RATE_LSB +: 2]), .out_hiz(out_hiz), .rate_sel(rate_sel)
    );

    assign reg_rd_data = mode_q;
    assign cm_wr_data  = {mode_q[PAT_LSB +: PAT_W], {LOW_W{1'b0}}};

    AST_WR_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        cm_wr_en |-> (reg_rd_data[START_BIT] && blk_prog_permit)); // R6
    AST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == FS_SWEEP_B && frame_pulse) |=> !reg_rd_data[START_BIT]); // R5
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_data[WORD_W-1:10] == '0); // R1
endmodule

// File: tb/cmf_bulk_init_tb.sv
module cmf_bulk_init_tb_top;
    localparam int DEPTH = 64;
    localparam int AW = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr_en = 0;
    logic [3:0] reg_wr_addr = 0;
    logic [15:0] reg_wr_data = 0, reg_rd_data, cm_wr_data;
    logic blk_prog_permit = 0, frame_pulse = 0, drive_en_in = 0;
    logic out_hiz, cm_wr_en;
    logic [1:0] rate_sel;
    logic [AW-1:0] cm_wr_addr;

    int tests = 0, fails = 0;
    int wr_cnt = 0, seq_err = 0, exp_next = 0;
    logic [15:0] mem [DEPTH];

    always #5 clk = ~clk;

    cmf_bulk_init #(.CM_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
        .blk_prog_permit(blk_prog_permit), .frame_pulse(frame_pulse),
        .drive_en_in(drive_en_in), .out_hiz(out_hiz), .rate_sel(rate_sel),
        .cm_wr_en(cm_wr_en), .cm_wr_addr(cm_wr_addr), .cm_wr_data(cm_wr_data)
    );

    always @(posedge clk) begin
        if (rst_n && cm_wr_en) begin
            if (int'(cm_wr_addr) != exp_next) seq_err <= seq_err + 1;
            exp_next <= int'(cm_wr_addr) + 1;
            mem[cm_wr_addr] <= cm_wr_data;
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wreg(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk); reg_wr_en = 1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk); reg_wr_en = 0;
    endtask

    task automatic frame();
        @(negedge clk); frame_pulse = 1;
        @(negedge clk); frame_pulse = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] cmd(input logic [4:0] pat, input bit st);
        return {6'b0, pat, st, 4'b0};
    endfunction

    // {wdata, drive_en, exp_rd, exp_hiz, exp_rate}
    localparam logic [35:0] VEC [8] = '{
        {16'h0000, 1'b0, 16'h0000, 1'b1, 2'b00},
        {16'h0008, 1'b0, 16'h0008, 1'b0, 2'b00},
        {16'h0000, 1'b1, 16'h0000, 1'b0, 2'b00},
        {16'h0009, 1'b1, 16'h0009, 1'b0, 2'b01},
        {16'h0002, 1'b0, 16'h0002, 1'b1, 2'b10},
        {16'h0003, 1'b0, 16'h0003, 1'b1, 2'b00},
        {16'hFC04, 1'b0, 16'h0004, 1'b1, 2'b00},
        {16'h03EB, 1'b0, 16'h03EB, 1'b0, 2'b00}
    };

    initial begin
        #2_000_000;
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int saved;
        idle(3);
        rst_n = 1;
        @(negedge clk);
        chk(reg_rd_data == 16'h0000, "R1", "reset value", reg_rd_data, 0);
        chk(cm_wr_en == 0, "R3", "no write after reset", cm_wr_en, 0);

        for (int i = 0; i < 8; i++) begin
            drive_en_in = VEC[i][19];
            wreg(4'd1, VEC[i][35:20]);
            chk(reg_rd_data == VEC[i][18:3], "R1", "readback", reg_rd_data, VEC[i][18:3]);
            chk(out_hiz == VEC[i][2], "R8", "hiz", out_hiz, VEC[i][2]);
            chk(rate_sel == VEC[i][1:0], "R9", "rate", rate_sel, VEC[i][1:0]);
        end
        drive_en_in = 0;

        wreg(4'd1, 16'h0000);
        wreg(4'd2, 16'h0009);
        chk(reg_rd_data == 16'h0000, "R10", "other address", reg_rd_data, 0);

        // full fill with pattern 0A
        for (int i = 0; i < DEPTH; i++) mem[i] = 16'hFFFF;
        blk_prog_permit = 1;
        exp_next = 0;
        wreg(4'd1, cmd(5'h0A, 1));
        idle(3);
        chk(cm_wr_en == 0, "R3", "idle until frame", cm_wr_en, 0);
        frame();
        chk(cm_wr_en && cm_wr_addr == 0, "R3", "first write addr 0", {cm_wr_en, 26'b0, cm_wr_addr}, 32'h8000_0000);
        chk(cm_wr_data == 16'h5000, "R4", "write data", cm_wr_data, 16'h5000);
        idle(40);
        chk(reg_rd_data[4] == 1, "R5", "start held mid-fill", reg_rd_data[4], 1);
        frame();
        idle(40);
        chk(reg_rd_data[4] == 1, "R5", "start held before 2nd pulse", reg_rd_data[4], 1);
        frame();
        chk(reg_rd_data[4] == 0, "R5", "self clear", reg_rd_data[4], 0);
        chk(wr_cnt == DEPTH, "R3", "write count", wr_cnt, DEPTH);
        chk(seq_err == 0, "R3", "sequential", seq_err, 0);
        saved = 0;
        for (int i = 0; i < DEPTH; i++) if (mem[i] != 16'h5000) saved++;
        chk(saved == 0, "R4", "memory content mismatches", saved, 0);

        // abort by clearing the start bit
        exp_next = 0;
        wreg(4'd1, cmd(5'h13, 1));
        frame();
        idle(10);
        wreg(4'd1, cmd(5'h13, 0));
        chk(cm_wr_en == 0, "R6", "writes stop", cm_wr_en, 0);
        saved = wr_cnt;
        frame(); frame(); idle(5);
        chk(wr_cnt == saved, "R6", "no later writes", wr_cnt, saved);
        chk(mem[0] == 16'h9800, "R6", "early word new", mem[0], 16'h9800);
        chk(mem[DEPTH-1] == 16'h5000, "R6", "late word kept", mem[DEPTH-1], 16'h5000);

        // abort by dropping permission
        exp_next = 0;
        wreg(4'd1, cmd(5'h07, 1));
        frame();
        idle(5);
        @(negedge clk); blk_prog_permit = 0; #1;
        chk(cm_wr_en == 0, "R7", "same-cycle block", cm_wr_en, 0);
        @(negedge clk);
        chk(reg_rd_data[4] == 0, "R7", "start cleared", reg_rd_data[4], 0);
        saved = wr_cnt;
        blk_prog_permit = 1;
        frame(); frame(); idle(5);
        chk(wr_cnt == saved, "R7", "no later writes", wr_cnt, saved);
        chk(mem[DEPTH-1] == 16'h5000, "R7", "late word kept", mem[DEPTH-1], 16'h5000);

        // no permission: start stored, no fill
        blk_prog_permit = 0;
        saved = wr_cnt;
        wreg(4'd1, cmd(5'h1F, 1));
        frame(); frame(); frame(); idle(3);
        chk(wr_cnt == saved, "R2", "no fill without permit", wr_cnt, saved);
        chk(reg_rd_data[4] == 1, "R2", "start stored", reg_rd_data[4], 1);
        blk_prog_permit = 1;
        wreg(4'd1, cmd(5'h1F, 1));
        frame(); frame(); frame(); idle(3);
        chk(wr_cnt == saved, "R2", "no edge no fill", wr_cnt, saved);

        // fresh edge runs a full fill
        wreg(4'd1, cmd(5'h1F, 0));
        exp_next = 0;
        wreg(4'd1, cmd(5'h1F, 1));
        frame(); idle(40); frame(); idle(40); frame();
        chk(wr_cnt == saved + DEPTH, "R2", "fill after new edge", wr_cnt, saved + DEPTH);
        saved = 0;
        for (int i = 0; i < DEPTH; i++) if (mem[i] != 16'hF800) saved++;
        chk(saved == 0, "R4", "pattern 1F content mismatches", saved, 0);
        chk(reg_rd_data == 16'h03E0, "R5", "register after fill", reg_rd_data, 16'h03E0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule